// File: doc/BRIEF.md
# Pin Controller with Edge-Capture Interrupts

This block owns a bank of general-purpose pins (28 by default) and is programmed over a simple word-addressed register bus. Each pin can be an input or an output. An output pin is driven from a latch that software changes only through separate bit-set and bit-clear writes, so that different pieces of software can change different pins without a read-modify-write. Incoming pin levels are brought into the clock domain through a two-stage synchronizer. The synchronized levels can be read back and are watched for transitions.

Software enables rising-edge capture, falling-edge capture or both on each pin. A captured transition sets a sticky per-pin flag, and software clears that flag by writing a one to it. The block raises one interrupt line whenever any flag is set. A per-pin select can also hand the pad over to a peripheral. When the select is set, the peripheral's data and enable drive the pin in place of the latch and the direction bit.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: The level view (byte address 0x00) returns the pin inputs after two clock registers. A pin change that is sampled at one clock edge shows in the read data after the next edge. Writes to this address change nothing.
- R2: The direction view (0x04) is read/write. When a pin's peripheral select is 0, `pin_oe` for that pin equals its direction bit (1 = output).
- R3: A write to the set address (0x08) makes every latch bit written as 1 go to 1 and leaves the other latch bits as they were. When the peripheral select is 0, `pin_out` shows the latch.
- R4: A write to the clear address (0x0C) makes every latch bit written as 1 go to 0 and leaves the other latch bits as they were.
- R5: Reads of the set and clear addresses return zero.
- R6: The rising-enable (0x10) and falling-enable (0x14) views are read/write. A synchronized 0-to-1 change on a pin with its rising bit set, or a 1-to-0 change with its falling bit set, sets that pin's flag one cycle after the change appears in the level view. A change on a pin with neither bit set sets no flag.
- R7: The flag view (0x18) holds flags until they are cleared. A write clears each flag written as 1, and flags written as 0 keep their value.
- R8: If a capture and a clear of the same flag happen in the same cycle, the flag ends up set.
- R9: `irq` is 1 exactly when at least one flag is set.
- R10: The peripheral-select view (0x1C) is read/write. For a pin with its select bit at 1, `pin_out` and `pin_oe` follow `periph_out` and `periph_oe`.
- R11: A clock edge with `rst_n` low clears every register. After reset all outputs are 0, including `irq`.
- R12: Views sit one 32-bit word apart at the offsets given above, and address bits 1:0 are ignored. Read-data bits above the pin count read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register view |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 28 | Asynchronous pad input levels |
| pin_out | output | 28 | Pad output data |
| pin_oe | output | 28 | Pad output enable, 1 = drive |
| periph_out | input | 28 | Peripheral data for selected pins |
| periph_oe | input | 28 | Peripheral output enable for selected pins |
| irq | output | 1 | Any captured edge pending |

## Verification
Directed patterns come first. An alternating bit pattern is set and then partly cleared, which separates a true set/clear from a plain overwrite of the latch. Pins with only rising capture, only falling capture, both, or none are then toggled in both directions, which shows whether each enable gates the correct polarity. A clear is timed to land in the exact cycle of a new capture, which separates edge-wins from clear-wins. Random pin activity is then mixed with random writes to every address, with a behavioural model compared on every cycle. This exposes synchronizer latency errors, leakage between views and wrong readback on write-only addresses.

// File: rtl/gpio_pkg.sv
// Shared constants and the register-view selector for the pin controller.
package gpio_pkg;
    localparam int DATA_W = 32;

    // Word index of each register view (byte address bits 4:2).
    typedef enum logic [2:0] {
        SEL_LEVEL = 3'd0,
        SEL_DIR   = 3'd1,
        SEL_SET   = 3'd2,
        SEL_CLR   = 3'd3,
        SEL_RISE  = 3'd4,
        SEL_FALL  = 3'd5,
        SEL_FLAG  = 3'd6,
        SEL_ALT   = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
// Two-stage synchronizer for a vector of asynchronous pin inputs.
// Assumes each bit is independent; no multi-bit coherence is promised.
module gpio_sync #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Shift the raw levels through two registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;
endmodule

// File: rtl/gpio_edge.sv
// Per-pin edge capture: compares the synchronized level with its previous
// value, qualifies by rising/falling enables and keeps sticky flags.
// Assumes clr_mask is a one-cycle pulse from the register file; a capture
// in the same cycle as a clear wins.
module gpio_edge #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] hit,
    output logic [W-1:0] flags
);
    logic [W-1:0] level_d;
    logic [W-1:0] flags_q;

    // Remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= '0;
        else        level_d <= level;
    end

    // Qualify transitions per pin by polarity enable.
    generate
        for (genvar i = 0; i < W; i++) begin : g_det
            assign hit[i] = (rise_en[i] &  level[i] & ~level_d[i])
                          | (fall_en[i] & ~level[i] &  level_d[i]);
        end
    endgenerate

    // Sticky flags: new captures set, write-one clears, capture has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= hit | (flags_q & ~clr_mask);
    end

    assign flags = flags_q;

    // R7: a flag not written with 1 never drops.
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(flags_q) & ~$past(clr_mask) & ~flags_q) == '0));

    // R8: a capture always leaves its flag set, even under a clear.
    p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(hit) & ~flags_q) == '0));

    // R6: a flag only rises where a capture was seen the cycle before.
    p_flag_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags_q & ~$past(flags_q) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_regs.sv
// Register file for the pin controller: decodes the word-addressed bus,
// holds direction, latch, enables and peripheral selects, produces a
// one-cycle flag-clear mask and the read multiplexer.
// Assumes single-cycle writes and combinational reads; W <= DATA_W.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W      = 28,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [W-1:0]      level,
    input  logic [W-1:0]      flags,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      latch_q,
    output logic [W-1:0]      rise_q,
    output logic [W-1:0]      fall_q,
    output logic [W-1:0]      alt_q,
    output logic [W-1:0]      clr_mask
);
    reg_sel_e     sel;
    logic [W-1:0] wd;
    logic         wr_dir, wr_set, wr_clr, wr_rise, wr_fall, wr_flag, wr_alt;
    logic         unused_bits;

    assign sel = reg_sel_e'(bus_addr[4:2]);
    assign wd  = bus_wdata[W-1:0];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:W]};

    // Decode one write strobe per view.
    always_comb begin
        wr_dir  = bus_we && (sel == SEL_DIR);
        wr_set  = bus_we && (sel == SEL_SET);
        wr_clr  = bus_we && (sel == SEL_CLR);
        wr_rise = bus_we && (sel == SEL_RISE);
        wr_fall = bus_we && (sel == SEL_FALL);
        wr_flag = bus_we && (sel == SEL_FLAG);
        wr_alt  = bus_we && (sel == SEL_ALT);
    end

    // Plain read/write configuration views.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            alt_q  <= '0;
        end else begin
            if (wr_dir)  dir_q  <= wd;
            if (wr_rise) rise_q <= wd;
            if (wr_fall) fall_q <= wd;
            if (wr_alt)  alt_q  <= wd;
        end
    end

    // Output latch, changed only by bit-set and bit-clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= '0;
        else if (wr_set) latch_q <= latch_q | wd;
        else if (wr_clr) latch_q <= latch_q & ~wd;
    end

    // One-cycle mask of flags to clear.
    assign clr_mask = wr_flag ? wd : '0;

    // Read multiplexer; write-only views return zero.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_LEVEL: bus_rdata[W-1:0] = level;
            SEL_DIR:   bus_rdata[W-1:0] = dir_q;
            SEL_RISE:  bus_rdata[W-1:0] = rise_q;
            SEL_FALL:  bus_rdata[W-1:0] = fall_q;
            SEL_FLAG:  bus_rdata[W-1:0] = flags;
            SEL_ALT:   bus_rdata[W-1:0] = alt_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R3: after a set write every written-one bit is high.
    p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_set)) |-> ((latch_q & $past(wd)) == $past(wd)));

    // R4: after a clear write every written-one bit is low.
    p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_clr)) |-> ((latch_q & $past(wd)) == '0));

    // R3/R4: the latch holds when neither write-only view is written.
    p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_set) && !$past(wr_clr)) |-> $stable(latch_q));
endmodule

// File: rtl/gpio_edge_ctrl.sv
// Top of the pin controller: synchronizer, edge capture, register file and
// per-pin output steering between the GPIO latch and a peripheral.
// Assumes pads, peripherals and low-power states live outside this block.
module gpio_edge_ctrl
    import gpio_pkg::*;
#(
    parameter int PINS   = 28,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    input  logic [PINS-1:0]   periph_out,
    input  logic [PINS-1:0]   periph_oe,
    output logic              irq
);
    logic [PINS-1:0] level, hit, flags, clr_mask;
    logic [PINS-1:0] dir_q, latch_q, rise_q, fall_q, alt_q;

    gpio_sync #(.W(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (level)
    );

    gpio_edge #(.W(PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level),
        .rise_en  (rise_q),
        .fall_en  (fall_q),
        .clr_mask (clr_mask),
        .hit      (hit),
        .flags    (flags)
    );

    gpio_regs #(.W(PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .level     (level),
        .flags     (flags),
        .dir_q     (dir_q),
        .latch_q   (latch_q),
        .rise_q    (rise_q),
        .fall_q    (fall_q),
        .alt_q     (alt_q),
        .clr_mask  (clr_mask)
    );

    // Per-pin steering of data and enable.
    generate
        for (genvar i = 0; i < PINS; i++) begin : g_pin
            assign pin_out[i] = alt_q[i] ? periph_out[i] : latch_q[i];
            assign pin_oe[i]  = alt_q[i] ? periph_oe[i]  : dir_q[i];
        end
    endgenerate

    // Interrupt: any pending flag.
    assign irq = |flags;

    // R9: the interrupt only rises after a capture in the previous cycle.
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && irq && !$past(irq)) |-> ($past(hit) != '0));

    // R11: the cycle after a reset edge the interrupt is low.
    p_reset_quiet_r11: assert property (@(posedge clk)
        $past(!rst_n) |-> !irq);
endmodule

// File: tb/gpio_edge_ctrl_tb.sv
// Self-checking bench: a behavioural model updated on each rising edge and
// compared against the design shortly after every edge.
module gpio_edge_ctrl_tb;
    localparam int N = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe;
    logic [N-1:0]  periph_out = '0;
    logic [N-1:0]  periph_oe = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [N-1:0] m_pipe [0:2];   // [0] newest sample, [2] previous visible level
    logic [N-1:0] m_dir, m_lat, m_rise, m_fall, m_flag, m_alt;

    gpio_edge_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .periph_out(periph_out),
        .periph_oe(periph_oe), .irq(irq)
    );

    always #5 clk = ~clk;

    // Behavioural model of all views.
    always @(posedge clk) begin
        logic [N-1:0] edges, clr, d, vis;
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) m_pipe[k] = '0;
            m_dir = '0; m_lat = '0; m_rise = '0; m_fall = '0; m_flag = '0; m_alt = '0;
        end else begin
            d   = bus_wdata[N-1:0];
            vis = m_pipe[1];
            edges = (m_rise & vis & ~m_pipe[2]) | (m_fall & ~vis & m_pipe[2]);
            clr = (bus_we && bus_addr[4:2] == 3'd6) ? d : '0;
            m_flag = edges | (m_flag & ~clr);
            if (bus_we) begin
                case (bus_addr[4:2])
                    3'd1: m_dir = d;
                    3'd2: m_lat = m_lat | d;
                    3'd3: m_lat = m_lat & ~d;
                    3'd4: m_rise = d;
                    3'd5: m_fall = d;
                    3'd7: m_alt = d;
                    default: ;
                endcase
            end
            m_pipe[2] = m_pipe[1];
            m_pipe[1] = m_pipe[0];
            m_pipe[0] = pin_in;
        end
    end

    function automatic logic [31:0] exp_read(input logic [2:0] s);
        logic [31:0] r = '0;
        case (s)
            3'd0: r[N-1:0] = m_pipe[1];
            3'd1: r[N-1:0] = m_dir;
            3'd4: r[N-1:0] = m_rise;
            3'd5: r[N-1:0] = m_fall;
            3'd6: r[N-1:0] = m_flag;
            3'd7: r[N-1:0] = m_alt;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string read_tag(input logic [2:0] s);
        case (s)
            3'd0: return "R1 R12";
            3'd1: return "R2 R12";
            3'd2, 3'd3: return "R5 R12";
            3'd4, 3'd5: return "R6 R12";
            3'd6: return "R7 R8 R12";
            default: return "R10 R12";
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the edge.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            check(bus_rdata, exp_read(bus_addr[4:2]), read_tag(bus_addr[4:2]));
            check({4'b0, pin_out}, {4'b0, (m_alt & periph_out) | (~m_alt & m_lat)}, "R3 R4 R10");
            check({4'b0, pin_oe},  {4'b0, (m_alt & periph_oe)  | (~m_alt & m_dir)}, "R2 R10");
            check({31'b0, irq}, {31'b0, |m_flag}, "R9");
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(posedge clk); #2;
        // R11: reset state at the ports
        check(bus_rdata, 32'h0, "R11");
        check({4'b0, pin_out}, 32'h0, "R11");
        check({31'b0, irq}, 32'h0, "R11");

        // R3 R4: set alternating bits, clear some, outputs on half the pins
        wr(5'h04, 32'h0F0F0F0);
        wr(5'h08, 32'hAAAAAAA);
        wr(5'h0C, 32'h00000A0);
        @(posedge clk); #2;
        check({4'b0, pin_out}, {4'b0, 28'hAAAAA0A}, "R3 R4 directed");
        wr(5'h08, 32'h5);
        wr(5'h00, 32'hFFFFFFF);            // R1: ignored
        bus_addr = 5'h08; idle(2);         // R5: reads zero
        bus_addr = 5'h0C; idle(2);
        bus_addr = 5'h03; idle(2);         // R12: low bits ignored (word 0)

        // R6: rising on 0, falling on 1, both on 2, none on 3
        wr(5'h10, 32'h5);
        wr(5'h14, 32'h6);
        bus_addr = 5'h18;
        pin_in = 28'hF; idle(4);
        pin_in = 28'h0; idle(4);
        @(posedge clk); #2;
        check(bus_rdata, 32'h7, "R6 directed");

        // R7: clear only bit 1
        wr(5'h18, 32'h2);
        bus_addr = 5'h18; idle(1);
        @(posedge clk); #2;
        check(bus_rdata, 32'h5, "R7 directed");
        wr(5'h18, 32'hFFFFFFF);
        idle(1);

        // R8: edge on pin 0 lands in the same cycle as its clear
        @(negedge clk); pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 5'h18; bus_we = 1'b1; bus_wdata = 32'h1;
        @(negedge clk); bus_we = 1'b0;
        @(posedge clk); #2;
        check(bus_rdata, 32'h1, "R8 directed");
        check({31'b0, irq}, 32'h1, "R9 directed");
        wr(5'h18, 32'h1);
        idle(2);

        // R10: peripheral takes pins 8..15
        periph_out = 28'h0005A00; periph_oe = 28'h000FF00;
        wr(5'h1C, 32'h000FF00);
        idle(3);
        wr(5'h1C, 32'h0);

        // Mixed random traffic on all views
        for (int it = 0; it < 400; it++) begin
            @(negedge clk);
            pin_in = N'($urandom);
            periph_out = N'($urandom);
            periph_oe = N'($urandom);
            bus_addr = 5'($urandom);
            bus_we = ($urandom % 3) == 0;
            bus_wdata = $urandom;
        end
        @(negedge clk); bus_we = 1'b0;
        for (int a = 0; a < 8; a++) begin
            bus_addr = 5'(a * 4); idle(1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule